// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block lets an on-chip requester use an external asynchronous static RAM that is 16 bits wide and has a 17-bit word address. The requester offers one access at a time through a valid/ready handshake. Each access carries an address, write data, a direction flag and a two-bit lane enable. Bit 0 of the lane enable selects data bits 7:0, the lower byte. Bit 1 selects data bits 15:8, the upper byte. A read returns its data through a one-cycle response strobe.

On the memory side the controller drives registered active-low strobes: chip select, output enable, write enable, and one select per byte lane. The data bus is split into an outgoing value, a drive-enable for the pad and an incoming value. Write-enable-controlled writes are built from three timed phases:

- a setup phase, in which address, lane selects, chip select and data are already presented;
- a pulse phase, in which write enable is held low;
- a recovery phase, in which everything except write enable is held.

A read keeps chip select and output enable low for an access window and then samples the bus. Every phase length is a parameter counted in clock cycles. Each is obtained by rounding the memory's nanosecond limit up to whole clock periods.

The memory and the controller never drive the bus together. When an access reverses the bus direction, the controller inserts a quiet turnaround window before the new access.

Top module: `async_sram_ctrl`

## Requirements
- R1: During and directly after reset, `req_ready` is 1, `rsp_valid` is 0, all five memory strobes are high and `mem_dq_drive` is 0.
- R2: An access is accepted on a clock edge where `req_valid` and `req_ready` are both 1. For an access with a nonzero lane enable, `req_ready` is 0 from the cycle after acceptance through the last phase cycle of that access, and is 1 again in the next cycle.
- R3: A byte-lane select is low only while chip select is low and its lane-enable bit is 1 (`mem_lb_n` follows bit 0, `mem_ub_n` follows bit 1). When no access is in progress, all strobes are high and the bus is not driven.
- R4: A write with no turnaround starts in the cycle after acceptance. It presents the address, the write data, the data drive, chip select and the lane selects for SETUP_CYC cycles with write enable high.
- R5: Write enable is then low for exactly PULSE_CYC cycles. Address and data are unchanged and driven throughout.
- R6: After write enable rises, address, data, drive, chip select and lane selects are held for REC_CYC cycles. Output enable stays high for the whole write.
- R7: A read holds chip select, output enable and its lane selects low for ACCESS_CYC cycles without driving the bus. It samples the bus at the edge that ends the last of these cycles. In the next cycle it raises `rsp_valid` for one cycle. `rsp_rdata` holds the sampled selected lanes, and lanes not selected read as 0.
- R8: When an access's direction differs from that of the most recent access with a nonzero lane enable, TURN_CYC cycles with all strobes high and no drive precede it.
- R9: The data drive and a low output enable never occur in the same cycle.
- R10: An access with lane enable 2'b00 never asserts any strobe and never drops `req_ready`, and it does not change the remembered direction. For a read, `rsp_valid` is 1 in the next cycle with data 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access offered |
| req_ready | output | 1 | Controller can accept an access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane enable: bit 0 lower byte, bit 1 upper byte |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| mem_addr | output | 17 | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ub_n | output | 1 | Upper byte select, active low |
| mem_lb_n | output | 1 | Lower byte select, active low |
| mem_dq_out | output | 16 | Data toward memory |
| mem_dq_drive | output | 1 | Pad drive enable for mem_dq_out |
| mem_dq_in | input | 16 | Data from memory |

## Verification
The hardest behaviour to reach is the direction memory. A turnaround must appear only when a real access reverses the bus, and a no-op placed between a read and a write must neither trigger one nor reset the memory. The stimulus alternates directions on purpose and puts empty lane enables between opposite accesses. It keeps `req_valid` asserted while the controller is busy, so that an access is accepted in the same cycle as a read response. Partial-lane writes followed by single-lane reads expose any lane mixing: the memory model returns a filler pattern on unselected lanes, and that pattern must never reach `rsp_rdata`.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_TURN,
      ST_WSETUP,
      ST_WPULSE,
      ST_WREC,
      ST_RACC
   } sramc_state_e;

   typedef enum logic [1:0] {
      DIR_NONE,
      DIR_RD,
      DIR_WR
   } sramc_dir_e;

   function automatic int sramc_max5(input int a, input int b, input int c,
                                     input int d, input int e);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      if (e > m) m = e;
      return m;
   endfunction

   function automatic logic sramc_bus_busy(input sramc_state_e s);
      return (s == ST_WSETUP) || (s == ST_WPULSE) || (s == ST_WREC) || (s == ST_RACC);
   endfunction

endpackage

// File: rtl/sramc_phase_timer.sv
module sramc_phase_timer #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             last
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val - CNT_W'(1);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign last = (cnt_q == '0);

endmodule

// File: rtl/sramc_seq.sv
module sramc_seq
   import sramc_pkg::*;
#(
   parameter int CNT_W      = 3,
   parameter int SETUP_CYC  = 1,
   parameter int PULSE_CYC  = 2,
   parameter int REC_CYC    = 1,
   parameter int ACCESS_CYC = 3,
   parameter int TURN_CYC   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept,
   input  logic             req_write,
   input  logic [1:0]       req_be,
   input  logic             phase_last,
   output sramc_state_e     state,
   output sramc_state_e     state_nxt,
   output logic             timer_load,
   output logic [CNT_W-1:0] timer_val,
   output logic             capture
);

   localparam logic [CNT_W-1:0] SETUP_V  = CNT_W'(SETUP_CYC);
   localparam logic [CNT_W-1:0] PULSE_V  = CNT_W'(PULSE_CYC);
   localparam logic [CNT_W-1:0] REC_V    = CNT_W'(REC_CYC);
   localparam logic [CNT_W-1:0] ACCESS_V = CNT_W'(ACCESS_CYC);
   localparam logic [CNT_W-1:0] TURN_V   = CNT_W'(TURN_CYC);

   sramc_state_e state_q;
   sramc_dir_e   dir_q;
   sramc_dir_e   dir_req;
   logic         op_wr_q;
   logic         real_op;
   logic         turn_needed;

   assign real_op     = accept && (req_be != 2'b00);
   assign dir_req     = req_write ? DIR_WR : DIR_RD;
   assign turn_needed = (dir_q != DIR_NONE) && (dir_q != dir_req);

   always_comb begin
      state_nxt  = state_q;
      timer_load = 1'b0;
      timer_val  = SETUP_V;
      capture    = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (real_op) begin
               timer_load = 1'b1;
               if (turn_needed) begin
                  state_nxt = ST_TURN;
                  timer_val = TURN_V;
               end else if (req_write) begin
                  state_nxt = ST_WSETUP;
                  timer_val = SETUP_V;
               end else begin
                  state_nxt = ST_RACC;
                  timer_val = ACCESS_V;
               end
            end
         end
         ST_TURN: begin
            if (phase_last) begin
               timer_load = 1'b1;
               if (op_wr_q) begin
                  state_nxt = ST_WSETUP;
                  timer_val = SETUP_V;
               end else begin
                  state_nxt = ST_RACC;
                  timer_val = ACCESS_V;
               end
            end
         end
         ST_WSETUP: begin
            if (phase_last) begin
               timer_load = 1'b1;
               state_nxt  = ST_WPULSE;
               timer_val  = PULSE_V;
            end
         end
         ST_WPULSE: begin
            if (phase_last) begin
               timer_load = 1'b1;
               state_nxt  = ST_WREC;
               timer_val  = REC_V;
            end
         end
         ST_WREC: begin
            if (phase_last) state_nxt = ST_IDLE;
         end
         ST_RACC: begin
            if (phase_last) begin
               state_nxt = ST_IDLE;
               capture   = 1'b1;
            end
         end
         default: state_nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         dir_q   <= DIR_NONE;
         op_wr_q <= 1'b0;
      end else begin
         state_q <= state_nxt;
         if (real_op) begin
            dir_q   <= dir_req;
            op_wr_q <= req_write;
         end
      end
   end

   assign state = state_q;

endmodule

// File: rtl/sramc_lane_ctl.sv
module sramc_lane_ctl #(
   parameter int LANES  = 2,
   parameter int LANE_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bus_on_d,
   input  logic [LANES-1:0]        be_d,
   input  logic [LANES-1:0]        be_q,
   input  logic                    capture,
   input  logic                    clear,
   input  logic [LANES*LANE_W-1:0] dq_in,
   output logic [LANES-1:0]        lane_n,
   output logic [LANES*LANE_W-1:0] rdata
);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic              sel_n_q;
      logic [LANE_W-1:0] byte_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sel_n_q <= 1'b1;
         end else begin
            sel_n_q <= ~(bus_on_d & be_d[i]);
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            byte_q <= '0;
         end else if (clear) begin
            byte_q <= '0;
         end else if (capture) begin
            byte_q <= be_q[i] ? dq_in[i*LANE_W +: LANE_W] : '0;
         end
      end

      assign lane_n[i]                 = sel_n_q;
      assign rdata[i*LANE_W +: LANE_W] = byte_q;
   end

endmodule

// File: rtl/sramc_pin_reg.sv
module sramc_pin_reg
   import sramc_pkg::*;
#(
   parameter int ADDR_W = 17,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  sramc_state_e      state_nxt,
   input  logic              accept,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              rsp_set,
   output logic              cs_n,
   output logic              oe_n,
   output logic              we_n,
   output logic              drive,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] dout,
   output logic              rsp_valid
);

   logic wr_phase_d;

   assign wr_phase_d = (state_nxt == ST_WSETUP) || (state_nxt == ST_WPULSE) ||
                       (state_nxt == ST_WREC);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_n      <= 1'b1;
         oe_n      <= 1'b1;
         we_n      <= 1'b1;
         drive     <= 1'b0;
         rsp_valid <= 1'b0;
      end else begin
         cs_n      <= ~sramc_bus_busy(state_nxt);
         oe_n      <= ~(state_nxt == ST_RACC);
         we_n      <= ~(state_nxt == ST_WPULSE);
         drive     <= wr_phase_d;
         rsp_valid <= rsp_set;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr <= '0;
         dout <= '0;
      end else if (accept) begin
         addr <= req_addr;
         if (req_write) dout <= req_wdata;
      end
   end

endmodule

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl
   import sramc_pkg::*;
#(
   parameter int ADDR_W     = 17,
   parameter int LANE_W     = 8,
   parameter int SETUP_CYC  = 1,
   parameter int PULSE_CYC  = 2,
   parameter int REC_CYC    = 1,
   parameter int ACCESS_CYC = 3,
   parameter int TURN_CYC   = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic                req_write,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [2*LANE_W-1:0] req_wdata,
   input  logic [1:0]          req_be,
   output logic                rsp_valid,
   output logic [2*LANE_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic                mem_cs_n,
   output logic                mem_oe_n,
   output logic                mem_we_n,
   output logic                mem_ub_n,
   output logic                mem_lb_n,
   output logic [2*LANE_W-1:0] mem_dq_out,
   output logic                mem_dq_drive,
   input  logic [2*LANE_W-1:0] mem_dq_in
);

   localparam int LANES   = 2;
   localparam int DATA_W  = LANES * LANE_W;
   localparam int MAX_CYC = sramc_max5(SETUP_CYC, PULSE_CYC, REC_CYC, ACCESS_CYC, TURN_CYC);
   localparam int CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC + 1);

   if (SETUP_CYC < 1 || PULSE_CYC < 1 || REC_CYC < 1 || ACCESS_CYC < 1 || TURN_CYC < 1)
   begin : g_bad_timing
      $error("async_sram_ctrl: every phase length must be at least one cycle");
   end
   if (ADDR_W < 1 || LANE_W < 1) begin : g_bad_width
      $error("async_sram_ctrl: address and lane widths must be positive");
   end

   sramc_state_e     state;
   sramc_state_e     state_nxt;
   logic             accept;
   logic             timer_load;
   logic [CNT_W-1:0] timer_val;
   logic             phase_last;
   logic             capture;
   logic             noop_rd;
   logic [1:0]       be_q;
   logic [1:0]       be_d;
   logic [1:0]       lane_n;

   assign req_ready = (state == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign noop_rd   = accept && !req_write && (req_be == 2'b00);
   assign be_d      = (state == ST_IDLE) ? req_be : be_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) be_q <= '0;
      else if (accept) be_q <= req_be;
   end

   sramc_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (timer_load),
      .load_val (timer_val),
      .last     (phase_last)
   );

   sramc_seq #(
      .CNT_W      (CNT_W),
      .SETUP_CYC  (SETUP_CYC),
      .PULSE_CYC  (PULSE_CYC),
      .REC_CYC    (REC_CYC),
      .ACCESS_CYC (ACCESS_CYC),
      .TURN_CYC   (TURN_CYC)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (accept),
      .req_write  (req_write),
      .req_be     (req_be),
      .phase_last (phase_last),
      .state      (state),
      .state_nxt  (state_nxt),
      .timer_load (timer_load),
      .timer_val  (timer_val),
      .capture    (capture)
   );

   sramc_lane_ctl #(.LANES(LANES), .LANE_W(LANE_W)) u_lanes (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_on_d (sramc_bus_busy(state_nxt)),
      .be_d     (be_d),
      .be_q     (be_q),
      .capture  (capture),
      .clear    (noop_rd),
      .dq_in    (mem_dq_in),
      .lane_n   (lane_n),
      .rdata    (rsp_rdata)
   );

   sramc_pin_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
      .clk       (clk),
      .rst_n     (rst_n),
      .state_nxt (state_nxt),
      .accept    (accept),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .rsp_set   (capture | noop_rd),
      .cs_n      (mem_cs_n),
      .oe_n      (mem_oe_n),
      .we_n      (mem_we_n),
      .drive     (mem_dq_drive),
      .addr      (mem_addr),
      .dout      (mem_dq_out),
      .rsp_valid (rsp_valid)
   );

   assign mem_lb_n = lane_n[0];
   assign mem_ub_n = lane_n[1];

endmodule

// File: rtl/sramc_checker.sv
module sramc_checker #(
   parameter int ADDR_W = 17,
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_cs_n,
   input logic              mem_oe_n,
   input logic              mem_we_n,
   input logic              mem_ub_n,
   input logic              mem_lb_n,
   input logic [DATA_W-1:0] mem_dq_out,
   input logic              mem_dq_drive
);

   // R9: pad drive and memory output enable never overlap
   a_r9_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_dq_drive && !mem_oe_n));

   // R3: a lane select is only low under chip select
   a_r3_lane_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ub_n || !mem_lb_n) |-> !mem_cs_n);

   // R3: chip select low always comes with at least one lane
   a_r3_cs_has_lane: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_cs_n |-> (!mem_ub_n || !mem_lb_n));

   // R2: no acceptance while the memory is being accessed
   a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_cs_n |-> !req_ready);

   // R4: write enable only falls after a setup cycle under chip select with data driven
   a_r4_setup_first: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_we_n) |-> ($past(!mem_cs_n) && $past(mem_dq_drive) && $stable(mem_addr)));

   // R5: address and data hold during the pulse
   a_r5_pulse_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

   // R6: recovery keeps chip select, drive and address after write enable rises
   a_r6_recovery_hold: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (!mem_cs_n && mem_dq_drive && $stable(mem_addr) && $stable(mem_dq_out)));

   // R7: the end of a read window is the response cycle
   a_r7_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_oe_n) |-> rsp_valid);

endmodule

bind async_sram_ctrl sramc_checker #(.ADDR_W(ADDR_W), .DATA_W(2*LANE_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_ready    (req_ready),
   .rsp_valid    (rsp_valid),
   .mem_addr     (mem_addr),
   .mem_cs_n     (mem_cs_n),
   .mem_oe_n     (mem_oe_n),
   .mem_we_n     (mem_we_n),
   .mem_ub_n     (mem_ub_n),
   .mem_lb_n     (mem_lb_n),
   .mem_dq_out   (mem_dq_out),
   .mem_dq_drive (mem_dq_drive)
);

// File: tb/async_sram_ctrl_tb.sv
module async_sram_ctrl_tb;

   localparam int S = 2, P = 3, RC = 1, A = 3, T = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [16:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [1:0]  req_be = '0;
   logic        req_ready, rsp_valid;
   logic [15:0] rsp_rdata;
   logic [16:0] mem_addr;
   logic        mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_drive;
   logic [15:0] mem_dq_out, mem_dq_in;

   always #2 clk = ~clk;

   async_sram_ctrl #(
      .SETUP_CYC(S), .PULSE_CYC(P), .REC_CYC(RC), .ACCESS_CYC(A), .TURN_CYC(T)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
      .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
      .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n), .mem_dq_out(mem_dq_out),
      .mem_dq_drive(mem_dq_drive), .mem_dq_in(mem_dq_in)
   );

   // ---------------- behavioural memory (64 words, indexed by address bits 5:0)
   logic [15:0] sram_m [64];
   logic [15:0] shadow [64];

   function automatic logic [15:0] seed_word(input int i);
      return 16'(i * 257) ^ 16'h5A3C;
   endfunction

   initial for (int i = 0; i < 64; i++) sram_m[i] = seed_word(i);
   initial for (int i = 0; i < 64; i++) shadow[i] = seed_word(i);

   always_comb begin
      mem_dq_in = 16'hA5A5;
      if (!mem_cs_n && !mem_oe_n && mem_we_n) begin
         if (!mem_lb_n) mem_dq_in[7:0]  = sram_m[mem_addr[5:0]][7:0];
         if (!mem_ub_n) mem_dq_in[15:8] = sram_m[mem_addr[5:0]][15:8];
      end
   end

   always @(posedge mem_we_n) begin
      if (rst_n && !mem_cs_n && mem_dq_drive) begin
         if (!mem_lb_n) sram_m[mem_addr[5:0]][7:0]  = mem_dq_out[7:0];
         if (!mem_ub_n) sram_m[mem_addr[5:0]][15:8] = mem_dq_out[15:8];
      end
   end

   // ---------------- cycle reference model
   typedef struct {
      bit          rdy;
      bit          rv;
      logic [15:0] rd;
      bit          cs, oe, we, ub, lb, drv;
      logic [16:0] addr;
      logic [15:0] dout;
      string       tag;
   } exp_t;

   exp_t   q[$];
   int     last_dir;   // 0 none, 1 read, 2 write
   int     total = 0;
   int     bad = 0;
   bit     done = 1'b0;

   function automatic exp_t mk(bit rdy, bit rv, logic [15:0] rd, bit cs, bit oe, bit we,
                               bit ub, bit lb, bit drv, logic [16:0] a, logic [15:0] d,
                               string tag);
      exp_t e;
      e.rdy = rdy; e.rv = rv; e.rd = rd; e.cs = cs; e.oe = oe; e.we = we;
      e.ub = ub; e.lb = lb; e.drv = drv; e.addr = a; e.dout = d; e.tag = tag;
      return e;
   endfunction

   function automatic exp_t idle_e();
      return mk(1, 0, 16'h0, 1, 1, 1, 1, 1, 0, '0, '0, "R3");
   endfunction

   task automatic push_op();
      int          idx;
      int          dir;
      logic [15:0] w;
      idx = int'(req_addr[5:0]);
      dir = req_write ? 2 : 1;
      if (req_be == 2'b00) begin
         // R10: empty lane enable
         if (!req_write) q.push_back(mk(1, 1, 16'h0, 1, 1, 1, 1, 1, 0, '0, '0, "R10"));
      end else begin
         if (last_dir != 0 && last_dir != dir)
            for (int k = 0; k < T; k++) q.push_back(mk(0, 0, 0, 1, 1, 1, 1, 1, 0, '0, '0, "R8"));
         if (req_write) begin
            for (int k = 0; k < S; k++)
               q.push_back(mk(0, 0, 0, 0, 1, 1, !req_be[1], !req_be[0], 1, req_addr, req_wdata, "R4"));
            for (int k = 0; k < P; k++)
               q.push_back(mk(0, 0, 0, 0, 1, 0, !req_be[1], !req_be[0], 1, req_addr, req_wdata, "R5"));
            for (int k = 0; k < RC; k++)
               q.push_back(mk(0, 0, 0, 0, 1, 1, !req_be[1], !req_be[0], 1, req_addr, req_wdata, "R6"));
            if (req_be[0]) shadow[idx][7:0]  = req_wdata[7:0];
            if (req_be[1]) shadow[idx][15:8] = req_wdata[15:8];
         end else begin
            for (int k = 0; k < A; k++)
               q.push_back(mk(0, 0, 0, 0, 0, 1, !req_be[1], !req_be[0], 0, req_addr, '0, "R7"));
            w = shadow[idx];
            if (!req_be[0]) w[7:0]  = 8'h00;
            if (!req_be[1]) w[15:8] = 8'h00;
            q.push_back(mk(1, 1, w, 1, 1, 1, 1, 1, 0, '0, '0, "R7"));
         end
         last_dir = dir;
      end
   endtask

   always @(posedge clk) begin
      exp_t cur;
      if (!rst_n) begin
         q.delete();
         last_dir = 0;
      end else begin
         cur = (q.size() != 0) ? q[0] : idle_e();
         if (q.size() != 0) void'(q.pop_front());
         if (req_valid && cur.rdy) push_op();
      end
   end

   always @(negedge clk) begin
      exp_t e;
      bit   ok;
      if (rst_n && !done) begin
         e  = (q.size() != 0) ? q[0] : idle_e();
         ok = 1'b1;
         total++;
         if (req_ready !== e.rdy) begin
            ok = 1'b0;
            $display("FAIL R2 ready: actual %0b expected %0b", req_ready, e.rdy);
         end
         if (rsp_valid !== e.rv || (e.rv && rsp_rdata !== e.rd)) begin
            ok = 1'b0;
            $display("FAIL %s response: actual v=%0b d=%h expected v=%0b d=%h",
                     e.tag, rsp_valid, rsp_rdata, e.rv, e.rd);
         end
         if ({mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_drive} !==
             {e.cs, e.oe, e.we, e.ub, e.lb, e.drv}) begin
            ok = 1'b0;
            $display("FAIL %s strobes cs/oe/we/ub/lb/drv: actual %b expected %b", e.tag,
                     {mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_drive},
                     {e.cs, e.oe, e.we, e.ub, e.lb, e.drv});
         end
         if (!e.cs && mem_addr !== e.addr) begin
            ok = 1'b0;
            $display("FAIL %s address: actual %h expected %h", e.tag, mem_addr, e.addr);
         end
         if (e.drv && mem_dq_out !== e.dout) begin
            ok = 1'b0;
            $display("FAIL %s write data: actual %h expected %h", e.tag, mem_dq_out, e.dout);
         end
         if (mem_dq_drive && !mem_oe_n) begin
            ok = 1'b0;
            $display("FAIL R9 contention: actual drive=1 oe_n=0 expected no overlap");
         end
         if (!ok) bad++;
      end
   end

   // ---------------- watchdog
   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL R2 watchdog: actual hung expected completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   // ---------------- stimulus
   task automatic issue(input bit wr, input logic [16:0] a, input logic [15:0] d,
                        input logic [1:0] be);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
      while (!req_ready) @(negedge clk);
      @(posedge clk);
   endtask

   task automatic quiet(input int n);
      @(negedge clk);
      req_valid = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   logic [15:0] lfsr = 16'hACE1;

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs while held in reset
      total++;
      if ({req_ready, rsp_valid, mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_drive}
          !== 8'b10111110) begin
         bad++;
         $display("FAIL R1 reset outputs: actual %b expected %b",
                  {req_ready, rsp_valid, mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n,
                   mem_dq_drive}, 8'b10111110);
      end
      rst_n = 1'b1;   // R1 continues in the model's idle entries after release
      quiet(2);

      issue(1, 17'h00005, 16'h1234, 2'b11);   // R4 R5 R6 word write
      issue(0, 17'h00005, 16'h0,    2'b11);   // R8 turnaround then R7 word read
      issue(1, 17'h00005, 16'hFFAB, 2'b01);   // R3 lower-lane write
      issue(0, 17'h00005, 16'h0,    2'b10);   // R7 upper-only read, lower lane zero
      issue(0, 17'h00005, 16'h0,    2'b01);   // R7 back-to-back read, no turnaround
      issue(1, 17'h00005, 16'h77EE, 2'b10);   // R3 upper-lane write
      issue(1, 17'h00005, 16'h9999, 2'b00);   // R10 empty write, memory untouched
      issue(0, 17'h00005, 16'h0,    2'b00);   // R10 empty read, no turnaround from it
      issue(1, 17'h00006, 16'h4242, 2'b11);   // R8 write after write: no turnaround
      issue(0, 17'h00005, 16'h0,    2'b11);   // R7 merged word 77AB
      issue(1, 17'h1FFFF, 16'hBEEF, 2'b11);   // top address
      issue(0, 17'h1FFFF, 16'h0,    2'b11);
      quiet(3);
      issue(0, 17'h00006, 16'h0,    2'b00);   // R10 empty read between read and write
      issue(1, 17'h00007, 16'h1357, 2'b11);   // R8 still turns (last real access was read)
      quiet(1);

      for (int n = 0; n < 300; n++) begin
         logic [16:0] a;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         a = (lfsr[8:3] == 6'd63) ? 17'h1FFFF : {lfsr[15:9], 4'b0000, lfsr[8:3]};
         issue(lfsr[0], a, {lfsr[7:0], lfsr[15:8]} ^ 16'h0F0F, lfsr[2:1]);
         if (lfsr[11:10] == 2'b00) quiet(int'(lfsr[13:12]));
      end
      // read back every word for the R7 data path
      for (int i = 0; i < 64; i++) issue(0, {11'h0, 6'(i)}, 16'h0, 2'b11);
      quiet(12);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule